// File: doc/BRIEF.md
# Bridge Read Prefetch Policy Selector

This block decides how a bridge forwards a read it has accepted from an initiator. For each request it takes the command, the address, the side that accepted the read, the bus mode (conventional or extended) and whether the address lies in prefetchable memory. From these it produces the byte count to request on the target side, the byte enables to drive there, a flag that tells the initiator side to disconnect after a single DWord, and a handling class (immediate, delayed or split).

Reads that must not be speculative fetch exactly one DWord and keep the initiator's byte enables. Prefetchable reads take their length from a per-command policy field. Each side has its own policy set. The length is then cut at the cache-line boundary, at the maximum read byte count, or at the next 1 MB address boundary, whichever applies. Results are registered and appear one cycle after a request strobe.

Top module: `bridge_rd_prefetch`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle with `reqValid` high, and low otherwise. On reset all outputs are zero. The other outputs keep their values while `outValid` is low.
- R2: Command codes are 0 I/O read, 1 Type 0 configuration read, 2 memory read, 3 memory read line, 4 memory read multiple and 5 DWord read. Codes 6 and 7 are treated like code 0. A read is non-prefetchable when it is code 0, 1, 5, 6 or 7, or when it is code 2 with `prefSpace` low. For such a read `outBytes` is 4, `outBe` equals `initBe`, and `outDiscOne` is 1.
- R3: Every prefetchable read drives `outBe` = 4'hF and `outDiscOne` = 0.
- R4: For a prefetchable memory read (code 2), the 2-bit memory-read policy selects the length: 00 gives one DWord (4 bytes), 01 reads to the cache-line boundary, and 10 or 11 fills the buffer.
- R5: For codes 3 and 4, the command's own fill bit selects the length: 0 reads to the cache-line boundary and 1 fills the buffer.
- R6: The cache-line length in bytes is 4*`cacheLineDw` minus the offset of the DWord-aligned address within the line. Address bits 1:0 are ignored. When `cacheLineDw` is zero, the cache-line length is 4 bytes. `cacheLineDw` is assumed to be a power of two.
- R7: The fill length is `maxReadBytes` rounded down to a multiple of 4, with a minimum of 4.
- R8: A prefetchable length never runs past the next 1 MB boundary. It is limited to 2^20 minus the DWord-aligned value of address bits 19:0.
- R9: `reqSide` 0 (primary) uses the `pri*` policy inputs and `reqSide` 1 (secondary) uses the `sec*` policy inputs. The policy inputs of the other side have no effect.
- R10: `outClass` is 0 (immediate) for a configuration read on the primary side. Every other read gets 1 (delayed) when `extMode` is 0 and 2 (split) when `extMode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqCmd | input | 3 | Read command code |
| reqAddr | input | ADDR_W (32) | Byte address of the read |
| reqSide | input | 1 | 0 primary, 1 secondary |
| extMode | input | 1 | 0 conventional, 1 extended mode |
| prefSpace | input | 1 | Address lies in prefetchable memory |
| initBe | input | 4 | Initiator byte enables |
| priMrSel | input | 2 | Primary memory-read policy |
| priMrlFill | input | 1 | Primary read-line fill bit |
| priMrmFill | input | 1 | Primary read-multiple fill bit |
| secMrSel | input | 2 | Secondary memory-read policy |
| secMrlFill | input | 1 | Secondary read-line fill bit |
| secMrmFill | input | 1 | Secondary read-multiple fill bit |
| cacheLineDw | input | CL_W (8) | Cache line size in DWords |
| maxReadBytes | input | MAXB_W (13) | Maximum read byte count |
| outValid | output | 1 | Result valid |
| outBytes | output | BOUND_LOG2+1 (21) | Target-side request length in bytes |
| outBe | output | 4 | Byte enables to drive |
| outDiscOne | output | 1 | Disconnect after one DWord |
| outClass | output | 2 | 0 immediate, 1 delayed, 2 split |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit cache line size, a 13-bit maximum read byte count and a 1 MB boundary. With a 13-bit count, fill requests can reach 8188 bytes. Together with addresses placed just below a 1 MB boundary, this lets the boundary cut shorten fill reads and cache-line reads alike. Cache line sizes sweep every power of two up to 128 DWords and zero, and maximum counts under 4 bytes reach the minimum-length rule.

// File: rtl/bridge_rd_pkg.sv
package bridge_rd_pkg;

  typedef enum logic [2:0] {
    CMD_IO   = 3'd0,
    CMD_CFG0 = 3'd1,
    CMD_MR   = 3'd2,
    CMD_MRL  = 3'd3,
    CMD_MRM  = 3'd4,
    CMD_DW   = 3'd5
  } rdCmd_e;

  typedef enum logic [1:0] {
    CLS_IMMEDIATE = 2'd0,
    CLS_DELAYED   = 2'd1,
    CLS_SPLIT     = 2'd2
  } rdClass_e;

  // strobes from the decode control to the length datapath
  typedef struct packed {
    logic     load;
    logic     nonPref;
    logic     useLine;
    logic     useFill;
    rdClass_e cls;
  } rdCtrl_t;

endpackage

// File: rtl/bridge_rd_ctrl.sv
module bridge_rd_ctrl
  import bridge_rd_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqCmd,
  input  logic       reqSide,
  input  logic       extMode,
  input  logic       prefSpace,
  input  logic [1:0] priMrSel,
  input  logic       priMrlFill,
  input  logic       priMrmFill,
  input  logic [1:0] secMrSel,
  input  logic       secMrlFill,
  input  logic       secMrmFill,
  output rdCtrl_t    ctrl
);

  logic [1:0] mrSel;
  logic       mrlFill;
  logic       mrmFill;

  // policy set follows the accepting side
  always_comb begin
    if (reqSide) begin
      mrSel   = secMrSel;
      mrlFill = secMrlFill;
      mrmFill = secMrmFill;
    end else begin
      mrSel   = priMrSel;
      mrlFill = priMrlFill;
      mrmFill = priMrmFill;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.load    = reqValid;
    ctrl.nonPref = 1'b1;
    unique case (reqCmd)
      CMD_MR: begin
        if (prefSpace) begin
          ctrl.nonPref = 1'b0;
          ctrl.useLine = (mrSel == 2'b01);
          ctrl.useFill = mrSel[1];
        end
      end
      CMD_MRL: begin
        ctrl.nonPref = 1'b0;
        ctrl.useFill = mrlFill;
        ctrl.useLine = ~mrlFill;
      end
      CMD_MRM: begin
        ctrl.nonPref = 1'b0;
        ctrl.useFill = mrmFill;
        ctrl.useLine = ~mrmFill;
      end
      default: ctrl.nonPref = 1'b1;
    endcase

    if ((reqCmd == CMD_CFG0) && !reqSide) ctrl.cls = CLS_IMMEDIATE;
    else if (extMode)                     ctrl.cls = CLS_SPLIT;
    else                                  ctrl.cls = CLS_DELAYED;
  end

endmodule

// File: rtl/bridge_rd_dp.sv
module bridge_rd_dp
  import bridge_rd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CL_W       = 8,
  parameter int MAXB_W     = 13,
  parameter int BOUND_LOG2 = 20,
  localparam int LEN_W     = BOUND_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        initBe,
  input  logic [CL_W-1:0]   cacheLineDw,
  input  logic [MAXB_W-1:0] maxReadBytes,
  output logic              outValid,
  output logic [LEN_W-1:0]  outBytes,
  output logic [3:0]        outBe,
  output logic              outDiscOne,
  output logic [1:0]        outClass
);

  localparam logic [LEN_W-1:0] DW_BYTES   = LEN_W'(4);
  localparam logic [LEN_W-1:0] BOUND_SIZE = LEN_W'(1) << BOUND_LOG2;

  logic [LEN_W-1:0] addrLow;
  logic [LEN_W-1:0] lineBytes;
  logic [LEN_W-1:0] lineOff;
  logic [LEN_W-1:0] lineLen;
  logic [LEN_W-1:0] fillRaw;
  logic [LEN_W-1:0] fillLen;
  logic [LEN_W-1:0] boundRem;
  logic [LEN_W-1:0] rawLen;
  logic [LEN_W-1:0] finalLen;

  assign addrLow   = {1'b0, reqAddr[BOUND_LOG2-1:2], 2'b00};
  assign lineBytes = LEN_W'(cacheLineDw) << 2;
  assign lineOff   = addrLow & (lineBytes - LEN_W'(1));
  assign lineLen   = (cacheLineDw == '0) ? DW_BYTES : (lineBytes - lineOff);
  assign fillRaw   = LEN_W'(maxReadBytes) & ~LEN_W'(3);
  assign fillLen   = (fillRaw < DW_BYTES) ? DW_BYTES : fillRaw;
  assign boundRem  = BOUND_SIZE - addrLow;

  always_comb begin
    if (ctrl.nonPref)      rawLen = DW_BYTES;
    else if (ctrl.useFill) rawLen = fillLen;
    else if (ctrl.useLine) rawLen = lineLen;
    else                   rawLen = DW_BYTES;
    finalLen = (rawLen > boundRem) ? boundRem : rawLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outBytes   <= '0;
      outBe      <= '0;
      outDiscOne <= 1'b0;
      outClass   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outBytes   <= finalLen;
        outBe      <= ctrl.nonPref ? initBe : 4'hF;
        outDiscOne <= ctrl.nonPref;
        outClass   <= ctrl.cls;
      end
    end
  end

  // control strobes must never select two lengths at once
  p_one_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> $onehot0({ctrl.nonPref, ctrl.useLine, ctrl.useFill}))
    else $error("p_one_mode_r4");

  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid)
    else $error("p_valid_next_r1");

  p_single_dw_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDiscOne) |-> (outBytes == DW_BYTES))
    else $error("p_single_dw_r2");

  p_full_be_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDiscOne) |-> (outBe == 4'hF))
    else $error("p_full_be_r3");

  p_no_cross_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> ((outBytes + $past(addrLow)) <= BOUND_SIZE))
    else $error("p_no_cross_r8");

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(outBytes))
    else $error("p_hold_r1");

endmodule

// File: rtl/bridge_rd_prefetch.sv
module bridge_rd_prefetch
  import bridge_rd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CL_W       = 8,
  parameter int MAXB_W     = 13,
  parameter int BOUND_LOG2 = 20,
  localparam int LEN_W     = BOUND_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSide,
  input  logic              extMode,
  input  logic              prefSpace,
  input  logic [3:0]        initBe,
  input  logic [1:0]        priMrSel,
  input  logic              priMrlFill,
  input  logic              priMrmFill,
  input  logic [1:0]        secMrSel,
  input  logic              secMrlFill,
  input  logic              secMrmFill,
  input  logic [CL_W-1:0]   cacheLineDw,
  input  logic [MAXB_W-1:0] maxReadBytes,
  output logic              outValid,
  output logic [LEN_W-1:0]  outBytes,
  output logic [3:0]        outBe,
  output logic              outDiscOne,
  output logic [1:0]        outClass
);

  rdCtrl_t ctrl;

  bridge_rd_ctrl uCtrl (
    .reqValid   (reqValid),
    .reqCmd     (reqCmd),
    .reqSide    (reqSide),
    .extMode    (extMode),
    .prefSpace  (prefSpace),
    .priMrSel   (priMrSel),
    .priMrlFill (priMrlFill),
    .priMrmFill (priMrmFill),
    .secMrSel   (secMrSel),
    .secMrlFill (secMrlFill),
    .secMrmFill (secMrmFill),
    .ctrl       (ctrl)
  );

  bridge_rd_dp #(
    .ADDR_W     (ADDR_W),
    .CL_W       (CL_W),
    .MAXB_W     (MAXB_W),
    .BOUND_LOG2 (BOUND_LOG2)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .reqAddr      (reqAddr),
    .initBe       (initBe),
    .cacheLineDw  (cacheLineDw),
    .maxReadBytes (maxReadBytes),
    .outValid     (outValid),
    .outBytes     (outBytes),
    .outBe        (outBe),
    .outDiscOne   (outDiscOne),
    .outClass     (outClass)
  );

endmodule

// File: tb/bridge_rd_prefetch_test.sv
module bridge_rd_prefetch_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqCmd = '0;
  logic [31:0] reqAddr = '0;
  logic        reqSide = 1'b0;
  logic        extMode = 1'b0;
  logic        prefSpace = 1'b0;
  logic [3:0]  initBe = '0;
  logic [1:0]  priMrSel = '0;
  logic        priMrlFill = 1'b0;
  logic        priMrmFill = 1'b0;
  logic [1:0]  secMrSel = '0;
  logic        secMrlFill = 1'b0;
  logic        secMrmFill = 1'b0;
  logic [7:0]  cacheLineDw = '0;
  logic [12:0] maxReadBytes = '0;
  logic        outValid;
  logic [20:0] outBytes;
  logic [3:0]  outBe;
  logic        outDiscOne;
  logic [1:0]  outClass;

  int errors = 0;
  int checks = 0;

  // expected state of the outputs
  bit    expValid = 0;
  int    expBytes = 0;
  int    expBe = 0;
  int    expDisc = 0;
  int    expCls = 0;
  string lenTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_rd_prefetch uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqSide(reqSide), .extMode(extMode),
    .prefSpace(prefSpace), .initBe(initBe), .priMrSel(priMrSel),
    .priMrlFill(priMrlFill), .priMrmFill(priMrmFill), .secMrSel(secMrSel),
    .secMrlFill(secMrlFill), .secMrmFill(secMrmFill),
    .cacheLineDw(cacheLineDw), .maxReadBytes(maxReadBytes),
    .outValid(outValid), .outBytes(outBytes), .outBe(outBe),
    .outDiscOne(outDiscOne), .outClass(outClass)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model of the requirements, applied to the current inputs
  task automatic model();
    int sel;
    int clB;
    int low;
    int rem;
    int f;
    bit nonp;
    expValid = reqValid;
    if (!reqValid) return;
    nonp = (reqCmd != 3'd2 && reqCmd != 3'd3 && reqCmd != 3'd4) ||
           (reqCmd == 3'd2 && !prefSpace);
    low = int'(reqAddr[19:0]) & 'hFFFFC;
    if (nonp) begin                       // R2
      expBytes = 4; expBe = initBe; expDisc = 1; lenTag = "R2";
    end else begin                        // R3
      expBe = 15; expDisc = 0;
      // R9: side picks the policy set; 0 one DW, 1 line, 2 fill
      if (reqCmd == 3'd2) begin           // R4
        sel = reqSide ? int'(secMrSel) : int'(priMrSel);
        sel = (sel >= 2) ? 2 : sel;
        lenTag = "R4";
      end else if (reqCmd == 3'd3) begin  // R5
        sel = (reqSide ? secMrlFill : priMrlFill) ? 2 : 1;
        lenTag = "R5";
      end else begin
        sel = (reqSide ? secMrmFill : priMrmFill) ? 2 : 1;
        lenTag = "R5";
      end
      if (sel == 0) expBytes = 4;
      else if (sel == 1) begin            // R6
        clB = int'(cacheLineDw) * 4;
        expBytes = (clB == 0) ? 4 : clB - (low % clB);
        lenTag = (clB == 0) ? "R6_zero" : "R6";
      end else begin                      // R7
        f = int'(maxReadBytes) & ~3;
        expBytes = (f < 4) ? 4 : f;
        lenTag = "R7";
      end
      rem = 1048576 - low;                // R8
      if (expBytes > rem) begin
        expBytes = rem; lenTag = "R8";
      end
    end
    // R10
    if (reqCmd == 3'd1 && !reqSide) expCls = 0;
    else expCls = extMode ? 2 : 1;
  endtask

  task automatic step();
    model();
    @(negedge clk);
    check("R1 valid", int'(outValid), int'(expValid));
    check({lenTag, " bytes"}, int'(outBytes), expBytes);
    check((expDisc != 0) ? "R2 be" : "R3 be", int'(outBe), expBe);
    check((expDisc != 0) ? "R2 disc" : "R3 disc", int'(outDiscOne), expDisc);
    check("R10 class", int'(outClass), expCls);
  endtask

  task automatic setReq(int cmd, int addr, bit side, bit ext, bit pref);
    reqValid = 1'b1; reqCmd = 3'(cmd); reqAddr = 32'(addr);
    reqSide = side; extMode = ext; prefSpace = pref;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", int'(outValid), 0);
    check("R1 reset bytes", int'(outBytes), 0);
    check("R1 reset class", int'(outClass), 0);
    rstN = 1'b1;
    @(negedge clk);

    initBe = 4'b0101; cacheLineDw = 8'd16; maxReadBytes = 13'd1024;
    priMrSel = 2'b01; secMrSel = 2'b10;
    priMrlFill = 1'b0; secMrlFill = 1'b1;
    priMrmFill = 1'b1; secMrmFill = 1'b0;

    // R2 non-prefetchable commands
    setReq(0, 'h100, 0, 0, 1); step();
    setReq(2, 'h100, 0, 0, 0); step();
    setReq(5, 'h100, 1, 1, 1); step();
    setReq(7, 'h104, 1, 0, 1); step();
    // R10 configuration read on each side and mode
    setReq(1, 'h0, 0, 0, 0); step();
    setReq(1, 'h0, 0, 1, 0); step();
    setReq(1, 'h0, 1, 0, 0); step();
    setReq(1, 'h0, 1, 1, 0); step();
    // R4 / R6 line from mid-line, R9 side select
    setReq(2, 'h1234, 0, 0, 1); step();   // 64 - 0x34 = 12
    setReq(2, 'h1234, 1, 0, 1); step();   // fill 1024
    priMrSel = 2'b00; setReq(2, 'h1234, 0, 0, 1); step(); // one DW
    priMrSel = 2'b11; setReq(2, 'h1234, 0, 1, 1); step(); // fill
    // R9 other side's policy has no effect
    secMrSel = 2'b00; setReq(2, 'h1234, 0, 1, 1); step();
    // R5 read line / multiple per side
    setReq(3, 'h2003, 0, 0, 1); step();
    setReq(3, 'h2003, 1, 0, 1); step();
    setReq(4, 'h2003, 0, 1, 1); step();
    setReq(4, 'h2003, 1, 1, 1); step();
    // R6 zero cache line size
    cacheLineDw = 8'd0; setReq(3, 'h40, 0, 0, 1); step();
    // R7 small and unaligned max counts
    maxReadBytes = 13'd2; setReq(4, 'h40, 0, 0, 1); step();
    maxReadBytes = 13'd8191; setReq(4, 'h40, 0, 0, 1); step();
    // R8 1 MB boundary truncation
    setReq(4, 'h3FFFF0, 0, 0, 1); step();  // 16 bytes left
    cacheLineDw = 8'd128; setReq(3, 'h1FFFF8, 0, 0, 0); step();
    // R1 idle cycles hold the fields
    reqValid = 1'b0; step(); step();

    // sweep
    for (int i = 0; i < 4000; i++) begin
      int a;
      a = int'($urandom);
      if ($urandom % 4 == 0) a = (a & 'hFFF00000) | ('hFFFFF - int'($urandom % 9000));
      setReq(int'($urandom % 8), a, 1'($urandom), 1'($urandom), 1'($urandom));
      reqValid = ($urandom % 5) != 0;
      initBe = 4'($urandom);
      priMrSel = 2'($urandom); secMrSel = 2'($urandom);
      priMrlFill = 1'($urandom); priMrmFill = 1'($urandom);
      secMrlFill = 1'($urandom); secMrmFill = 1'($urandom);
      cacheLineDw = ($urandom % 9 == 0) ? 8'd0 : 8'(1 << ($urandom % 8));
      maxReadBytes = 13'($urandom);
      step();
    end

    reqValid = 1'b0; step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule